// File: doc/BRIEF.md
# Peripheral Slot ROM Decoder

This block sits on the processor address bus and decodes the peripheral window from $C080 to $CFFF of an eight-slot system. On each bus access it decides who answers. The choice is one slot card, the internal ROM, or the decoder itself. The decoder itself answers status reads and reads of empty slots.

Each slot has 16 I/O locations. Slots 1 to 7 each have one 256-byte ROM page. All slots share one 2 KB expansion window. A slot takes ownership of the expansion window when its ROM page is accessed, and it keeps it until another slot's page is accessed.

Two soft-switch flags can hand the slot pages to internal ROM. A third flag is sticky: an access to the slot-3 page sets it and any access to $CFFF clears it. The decoder is purely combinational from the address to the selects. Only the flags and the owner slot are registered.

Top module: `slot_rom_decoder`

## Requirements
- R1: An access to $C080+16·n through $C08F+16·n (n = 0..7) asserts io_sel[n] alone and sets card_off to the address bits 3:0.
- R2: With the internal-page flag clear, an access to $Cn00–$CnFF (n = 1..7, except the case in R4) asserts page_sel[n] with card_off equal to address bits 7:0. The access also latches n as the expansion owner.
- R3: With the internal-page flag set, a read of $C100–$C7FF asserts int_rom_en and no select. A write there asserts neither. Neither changes the owner or the expansion flag.
- R4: With the internal-page flag clear and the slot-3 card flag clear, an access to $C300–$C3FF asserts no select and asserts int_rom_en on a read. It sets the expansion flag and latches owner 3.
- R5: With both the internal-page flag and the expansion flag clear, an access to $C800–$CFFE asserts exp_sel[owner] with card_off equal to address bits 10:0.
- R6: With either the internal-page flag or the expansion flag set, an access to $C800–$CFFE asserts no select, and a read asserts int_rom_en.
- R7: Any read or write of $CFFF clears the expansion flag and asserts no select. A read there asserts int_rom_en.
- R8: A read that selects a slot whose slot_present bit is 0 asserts own_drive with own_data = $FF. A write to such a slot does not assert own_drive.
- R9: A write to $C006 or $C007 sets the internal-page flag to address bit 0. A write to $C00A or $C00B sets the slot-3 card flag to address bit 0. Reads of these four addresses change nothing.
- R10: A read of $C015 returns the internal-page flag in bit 7, and a read of $C017 returns the expansion flag in bit 7. Bits 6:0 are zero, and own_drive is asserted.
- R11: Reset clears all three flags and sets the owner to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Bus access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Access address |
| slot_present | input | 8 | Card fitted, one bit per slot |
| io_sel | output | 8 | Slot I/O strobe |
| page_sel | output | 8 | Slot ROM page select |
| exp_sel | output | 8 | Expansion window select |
| card_off | output | 11 | Offset passed to the selected card |
| int_rom_en | output | 1 | Internal ROM supplies the read data |
| own_drive | output | 1 | Decoder supplies the read data |
| own_data | output | 8 | Decoder read data |

## Verification
The assertions assume that acc_addr and acc_write are stable and defined whenever acc_valid is high. They also assume that no access is presented during reset. The bench drives every input half a cycle ahead of the clock edge and holds acc_valid low through reset. The random addresses are weighted toward the I/O, page, expansion and $CFFF regions and the switch and status addresses, so that every flag combination meets every window.

// File: rtl/slot_rom_decoder.sv
module slot_rom_decoder #(
  parameter int SLOTS = 8,
  parameter int OFFW  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [15:0]      acc_addr,
  input  logic [SLOTS-1:0] slot_present,
  output logic [SLOTS-1:0] io_sel,
  output logic [SLOTS-1:0] page_sel,
  output logic [SLOTS-1:0] exp_sel,
  output logic [OFFW-1:0]  card_off,
  output logic             int_rom_en,
  output logic             own_drive,
  output logic [7:0]       own_data
);
  localparam int SW = $clog2(SLOTS);

  logic          int_slot, c3_card, int_exp;
  logic [SW-1:0] owner;

  logic          rd, wr;
  logic          in_io, in_page, in_exp, in_off;
  logic [SW-1:0] io_slot, pg_slot;
  logic          pg_c3_int, exp_int;

  assign rd = acc_valid & ~acc_write;
  assign wr = acc_valid &  acc_write;

  assign io_slot = acc_addr[4 +: SW];
  assign pg_slot = acc_addr[8 +: SW];

  assign in_io   = acc_addr[15:7] == 9'b1100_0000_1;
  assign in_page = acc_addr[15:11] == 5'b11000 && pg_slot != '0;
  assign in_exp  = acc_addr[15:11] == 5'b11001 && acc_addr[10:0] != 11'h7FF;
  assign in_off  = acc_addr == 16'hCFFF;

  assign pg_c3_int = !c3_card && pg_slot == SW'(3);
  assign exp_int   = int_slot | int_exp;

  always_comb begin
    io_sel     = '0;
    page_sel   = '0;
    exp_sel    = '0;
    card_off   = '0;
    int_rom_en = 1'b0;
    own_drive  = 1'b0;
    own_data   = 8'h00;
    if (acc_valid) begin
      if (in_io) begin
        io_sel[io_slot] = 1'b1;
        card_off        = OFFW'(acc_addr[3:0]);
        if (rd && !slot_present[io_slot]) begin
          own_drive = 1'b1;
          own_data  = 8'hFF;
        end
      end else if (in_page) begin
        if (int_slot || pg_c3_int) begin
          int_rom_en = rd;
        end else begin
          page_sel[pg_slot] = 1'b1;
          card_off          = OFFW'(acc_addr[7:0]);
          if (rd && !slot_present[pg_slot]) begin
            own_drive = 1'b1;
            own_data  = 8'hFF;
          end
        end
      end else if (in_exp) begin
        if (exp_int) begin
          int_rom_en = rd;
        end else begin
          exp_sel[owner] = 1'b1;
          card_off       = acc_addr[OFFW-1:0];
          if (rd && !slot_present[owner]) begin
            own_drive = 1'b1;
            own_data  = 8'hFF;
          end
        end
      end else if (in_off) begin
        int_rom_en = rd;
      end else if (rd && acc_addr == 16'hC015) begin
        own_drive = 1'b1;
        own_data  = {int_slot, 7'd0};
      end else if (rd && acc_addr == 16'hC017) begin
        own_drive = 1'b1;
        own_data  = {int_exp, 7'd0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_slot <= 1'b0;
      c3_card  <= 1'b0;
      int_exp  <= 1'b0;
      owner    <= '0;
    end else begin
      if (wr && acc_addr[15:1] == 15'h6003) int_slot <= acc_addr[0];
      if (wr && acc_addr[15:1] == 15'h6005) c3_card  <= acc_addr[0];
      if (acc_valid && in_page && !int_slot) begin
        owner <= pg_slot;
        if (pg_c3_int) int_exp <= 1'b1;
      end
      if (acc_valid && in_off) int_exp <= 1'b0;
    end
  end
endmodule

module slot_rom_decoder_chk #(
  parameter int SLOTS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [15:0]      acc_addr,
  input logic [SLOTS-1:0] io_sel,
  input logic [SLOTS-1:0] page_sel,
  input logic [SLOTS-1:0] exp_sel,
  input logic             int_rom_en,
  input logic             own_drive,
  input logic             int_slot,
  input logic             c3_card,
  input logic             int_exp
);
  p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_sel, page_sel, exp_sel}));

  p_int_page_no_card_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_slot |-> (page_sel == '0 && exp_sel == '0));

  p_c3_sets_exp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[15:8] == 8'hC3 && !int_slot && !c3_card) |=> int_exp);

  p_exp_internal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_exp |-> exp_sel == '0);

  p_cfff_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr == 16'hCFFF) |=> !int_exp);

  p_rom_not_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_rom_en && own_drive));

  p_write_no_rom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |-> !int_rom_en && !own_drive);
endmodule

bind slot_rom_decoder slot_rom_decoder_chk #(.SLOTS(SLOTS)) chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .io_sel(io_sel), .page_sel(page_sel), .exp_sel(exp_sel),
  .int_rom_en(int_rom_en), .own_drive(own_drive), .int_slot(int_slot),
  .c3_card(c3_card), .int_exp(int_exp)
);

// File: tb/slot_rom_decoder_test.sv
module slot_rom_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [15:0] acc_addr = 16'h0000;
  logic [7:0]  slot_present = 8'hFF;
  logic [7:0]  io_sel, page_sel, exp_sel;
  logic [10:0] card_off;
  logic        int_rom_en, own_drive;
  logic [7:0]  own_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  bit       m_slot, m_c3, m_exp;
  bit [2:0] m_own;

  always #10 clk = ~clk;

  slot_rom_decoder uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .slot_present(slot_present), .io_sel(io_sel),
    .page_sel(page_sel), .exp_sel(exp_sel), .card_off(card_off),
    .int_rom_en(int_rom_en), .own_drive(own_drive), .own_data(own_data)
  );

  function automatic logic [44:0] expect_out(bit v, bit w, logic [15:0] a, logic [7:0] pr,
                                             output string tag);
    logic [7:0] io, pg, ex, od;
    logic [10:0] off;
    logic rom, drv;
    bit rd;
    int s;
    io = 0; pg = 0; ex = 0; off = 0; rom = 0; drv = 0; od = 0;
    rd = v && !w;
    tag = "R9";
    if (v) begin
      if (a >= 16'hC080 && a <= 16'hC0FF) begin
        tag = "R1"; s = (a - 16'hC080) / 16;
        io[s] = 1; off = 11'(a % 16);
        if (rd && !pr[s]) begin drv = 1; od = 8'hFF; tag = "R8"; end
      end else if (a >= 16'hC100 && a <= 16'hC7FF) begin
        s = (a >> 8) & 7;
        if (m_slot) begin tag = "R3"; rom = rd; end
        else if (s == 3 && !m_c3) begin tag = "R4"; rom = rd; end
        else begin
          tag = "R2"; pg[s] = 1; off = 11'(a % 256);
          if (rd && !pr[s]) begin drv = 1; od = 8'hFF; tag = "R8"; end
        end
      end else if (a >= 16'hC800 && a <= 16'hCFFE) begin
        if (m_slot || m_exp) begin tag = "R6"; rom = rd; end
        else begin
          tag = "R5"; ex[m_own] = 1; off = 11'(a - 16'hC800);
          if (rd && !pr[m_own]) begin drv = 1; od = 8'hFF; tag = "R8"; end
        end
      end else if (a == 16'hCFFF) begin
        tag = "R7"; rom = rd;
      end else if (rd && a == 16'hC015) begin
        tag = "R10"; drv = 1; od = {m_slot, 7'd0};
      end else if (rd && a == 16'hC017) begin
        tag = "R10"; drv = 1; od = {m_exp, 7'd0};
      end
    end
    return {io, pg, ex, off, rom, drv, od};
  endfunction

  task automatic model_step(bit v, bit w, logic [15:0] a);
    int s;
    if (!v) return;
    if (w && (a == 16'hC006 || a == 16'hC007)) m_slot = a[0];
    if (w && (a == 16'hC00A || a == 16'hC00B)) m_c3 = a[0];
    if (a >= 16'hC100 && a <= 16'hC7FF && !m_slot) begin
      s = (a >> 8) & 7;
      m_own = 3'(s);
      if (s == 3 && !m_c3) m_exp = 1;
    end
    if (a == 16'hCFFF) m_exp = 0;
  endtask

  task automatic access(bit v, bit w, logic [15:0] a);
    logic [44:0] exp_v, act;
    string tag;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a;
    #5;
    exp_v = expect_out(v, w, a, slot_present, tag);
    act = {io_sel, page_sel, exp_sel, card_off, int_rom_en, own_drive, own_data};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h w=%0d actual=%h expected=%h", tag, a, w, act, exp_v);
    end
    model_step(v, w, a);
    @(posedge clk);
  endtask

  function automatic logic [15:0] rand_addr();
    int k;
    k = $urandom_range(0, 9);
    case (k)
      0: return 16'hC080 + 16'($urandom_range(0, 127));
      1, 2: return 16'hC100 + 16'($urandom_range(0, 16'h6FF));
      3: return 16'hC300 + 16'($urandom_range(0, 255));
      4, 5: return 16'hC800 + 16'($urandom_range(0, 16'h7FF));
      6: return 16'hCFFF;
      7: return 16'hC006 + 16'($urandom_range(0, 1)) + 16'(4 * $urandom_range(0, 1));
      8: return $urandom_range(0, 1) ? 16'hC015 : 16'hC017;
      default: return 16'($urandom_range(16'hC000, 16'hFFFF));
    endcase
  endfunction

  initial begin
    m_slot = 0; m_c3 = 0; m_exp = 0; m_own = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R11: reset state seen through status reads and expansion owner
    access(1, 0, 16'hC015);
    access(1, 0, 16'hC017);
    access(1, 0, 16'hC900);
    // R1 I/O strobes slot 0 and 7
    access(1, 0, 16'hC080);
    access(1, 1, 16'hC0FF);
    // R2 page select, owner latch, R5 expansion
    access(1, 0, 16'hC512);
    access(1, 0, 16'hCABC);
    // R4 slot 3 internal, sets expansion flag; R6; R10
    access(1, 0, 16'hC3A0);
    access(1, 0, 16'hC017);
    access(1, 1, 16'hC800);
    access(1, 0, 16'hCFFE);
    // R7 clear via write
    access(1, 1, 16'hCFFF);
    access(1, 0, 16'hC017);
    access(1, 0, 16'hCC00);
    // R9 slot-3 card flag on, slot-3 page goes to card
    access(1, 1, 16'hC00B);
    access(1, 0, 16'hC310);
    access(1, 0, 16'hC017);
    // R9 reads of switches ignored
    access(1, 0, 16'hC007);
    access(1, 0, 16'hC015);
    // R3 internal page flag
    access(1, 1, 16'hC007);
    access(1, 0, 16'hC015);
    access(1, 0, 16'hC600);
    access(1, 1, 16'hC200);
    access(1, 0, 16'hC900);
    access(1, 1, 16'hC006);
    access(1, 0, 16'hC900);
    // R8 empty slots
    slot_present = 8'b0101_0101;
    access(1, 0, 16'hC090);
    access(1, 1, 16'hC090);
    access(1, 0, 16'hC1FF);
    access(1, 0, 16'hC800);
    access(1, 0, 16'hCFFF);
    access(0, 0, 16'hC100);
    // random
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) slot_present = 8'($urandom);
      access($urandom_range(0, 7) != 0, $urandom_range(0, 1), rand_addr());
    end
    // R11: reset again mid-run
    @(negedge clk); acc_valid = 0; rst_n = 0;
    @(posedge clk); @(negedge clk); rst_n = 1;
    m_slot = 0; m_c3 = 0; m_exp = 0; m_own = 0;
    slot_present = 8'hFF;
    access(1, 0, 16'hC015);
    access(1, 0, 16'hC017);
    access(1, 0, 16'hC3FF);
    access(1, 0, 16'hC800);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule